// File: doc/BRIEF.md
# Chopper Current-Limit H-Bridge Controller

This block is the digital controller for a single full-bridge channel of a bipolar stepper motor driver. It turns an enable and a direction input into four gate commands, a high-side and a low-side command for each of the two output legs. With enable high, one diagonal pair of transistors conducts and the direction input picks which pair. With enable low, all four transistors are off and the winding is left floating.

The controller also limits winding current with a fixed-off-time chopper. A current-limit comparator flag ends the drive phase. The bridge then passes through a dead time with all transistors off and settles into short brake, with both low sides on. An off timer, clocked by an external oscillator flag, holds the brake for a fixed number of oscillator periods. A second dead time follows, and then drive resumes. A direction change while driving passes through the same dead time.

A global standby flag and a thermal-fault flag override everything and force the bridge off. Standby also clears the chopper's off timer. The comparator, oscillator, reference and power stage sit outside the block and arrive as synchronous digital flags.

The state machine has seven states:
- STANDBY: standby flag high, all gates off.
- HIZ: channel disabled or thermal fault, all gates off.
- DRIVE: the diagonal pair conducts.
- DEAD_BRK: all gates off on the way into brake.
- BRAKE: both low sides on.
- DEAD_DRV: all gates off on the way out of brake.
- DEAD_DIR: all gates off during a reversal.

Transitions:
- STANDBY or HIZ go to DRIVE when the block is enabled, with no standby and no fault.
- DRIVE goes to DEAD_BRK on a trip. It goes to DEAD_DIR when the direction input differs from the latched direction.
- DEAD_BRK goes to BRAKE once the dead count ends.
- BRAKE goes to DEAD_DRV when the off timer has expired and no trip is present. An expired timer with the trip present re-arms the timer and stays in BRAKE.
- DEAD_DRV and DEAD_DIR go to DRIVE once the dead count ends, latching the direction.
- From any state, standby goes to STANDBY, and a fault or a low enable goes to HIZ.

Top module: `hbridge_chopper_ctrl`

## Requirements
- R1: When `en` is low at a clock edge, all four gate outputs are 0 from that edge on, whatever the value of `dir`.
- R2: With `en` high and no standby or fault, `dir`=1 drives forward with `leg1_hi`=1 and `leg2_lo`=1 (gates {leg1_hi,leg1_lo,leg2_hi,leg2_lo}=1001). `dir`=0 drives reverse with 0110. Entering drive from the disabled state takes effect at the next edge, with no dead time.
- R3: When `stby` is high, all gates are 0 from the next edge, even in the middle of a brake. The off timer is cleared. When `stby` falls with `en` high, drive resumes at the next edge.
- R4: When `tsd` is high, all gates are 0 from the next edge, overriding `en` and `dir`. When `tsd` clears, drive resumes at the next edge.
- R5: When `trip` is high at an edge during drive, both high-side gates are off from that edge on.
- R6: After a trip, the gates stay at 0000 for exactly DEAD_CYCLES clock cycles. The bridge then enters short brake, 0101.
- R7: The off timer starts at the first rising edge of `osc` after the trip. It expires on the OFF_PERIODS-th rising edge after that start (the third edge in all, with the default of 2). Brake holds until one clock after the expiring edge is sampled.
- R8: When brake ends, the gates are 0000 for exactly DEAD_CYCLES cycles before drive resumes in the latched direction.
- R9: A change of `dir` during drive gives 0000 for exactly DEAD_CYCLES cycles, then drive in the new direction.
- R10: A `trip` pulse that arrives during brake or dead time is ignored. The brake ends at the same edge as it would without the pulse.
- R11: If `trip` is high when the off timer has expired in brake, a new off period starts at once. Brake continues with no dead time and needs a fresh start edge plus OFF_PERIODS further `osc` rising edges.
- R12: The high-side and low-side gates of the same leg are never 1 together in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; low leaves the bridge floating |
| dir | input | 1 | Direction: 1 forward, 0 reverse |
| trip | input | 1 | Current-limit comparator flag, synchronous |
| osc | input | 1 | Chopper oscillator flag, synchronous level |
| stby | input | 1 | Global standby flag |
| tsd | input | 1 | Thermal-fault flag |
| leg1_hi | output | 1 | High-side gate command, leg 1 |
| leg1_lo | output | 1 | Low-side gate command, leg 1 |
| leg2_hi | output | 1 | High-side gate command, leg 2 |
| leg2_lo | output | 1 | Low-side gate command, leg 2 |

## Verification
The hardest case to reach is the off timer expiring while the comparator flag is still high. That requires the trip to be held across exactly the clock edge where the timer's count reaches its end. The bench drives the oscillator flag by hand, one rising edge per task call, so it knows the edge on which the count completes. It raises `trip` just before the last oscillator edge and checks that brake continues with no dead gap. A trip pulse injected mid-brake is then shown to leave the release edge unchanged.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY  = 3'd0,
        ST_HIZ      = 3'd1,
        ST_DRIVE    = 3'd2,
        ST_DEAD_BRK = 3'd3,
        ST_BRAKE    = 3'd4,
        ST_DEAD_DRV = 3'd5,
        ST_DEAD_DIR = 3'd6
    } chop_state_e;

    typedef struct packed {
        logic hi1;
        logic lo1;
        logic hi2;
        logic lo2;
    } gate_cmd_t;

    function automatic logic is_dead(input chop_state_e s);
        return (s == ST_DEAD_BRK) || (s == ST_DEAD_DRV) || (s == ST_DEAD_DIR);
    endfunction

endpackage

// File: rtl/chop_dead_timer.sv
module chop_dead_timer #(
    parameter int DEAD_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(DEAD_CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R6 / R8: a freshly loaded dead window cannot end on its first cycle
    a_r6_dead_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (DEAD_CYCLES > 1)) |=> !done);

endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
    parameter int OFF_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc,
    input  logic arm,
    input  logic clear,
    output logic done
);
    localparam int TARGET = OFF_PERIODS + 1;
    localparam int CW     = $clog2(TARGET + 1);

    logic          osc_q;
    logic          osc_rise;
    logic          running;
    logic [CW-1:0] cnt;

    assign osc_rise = osc && !osc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q   <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            osc_q <= osc;
            if (clear) begin
                running <= 1'b0;
                cnt     <= '0;
            end else if (arm) begin
                running <= 1'b1;
                cnt     <= '0;
            end else if (running && osc_rise && (cnt != CW'(TARGET))) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = running && (cnt == CW'(TARGET));

    // R7: expiry only ever follows a sampled oscillator rising edge
    a_r7_expiry_on_osc_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(osc_rise));

    // R7: without an oscillator edge the count does not move
    a_r7_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !osc_rise && !arm && !clear) |=> $stable(cnt));

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        dir,
    input  logic        trip,
    input  logic        stby,
    input  logic        tsd,
    input  logic        dead_done,
    input  logic        off_done,
    output chop_state_e state,
    output logic        dir_q,
    output logic        dead_load,
    output logic        off_arm,
    output logic        off_clear
);
    chop_state_e next;

    // next-state logic
    always_comb begin
        next = state;
        unique case (state)
            ST_STANDBY, ST_HIZ: begin
                next = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (trip) begin
                    next = ST_DEAD_BRK;
                end else if (dir != dir_q) begin
                    next = ST_DEAD_DIR;
                end
            end
            ST_DEAD_BRK: begin
                if (dead_done) begin
                    next = ST_BRAKE;
                end
            end
            ST_BRAKE: begin
                if (off_done && !trip) begin
                    next = ST_DEAD_DRV;
                end
            end
            ST_DEAD_DRV, ST_DEAD_DIR: begin
                if (dead_done) begin
                    next = ST_DRIVE;
                end
            end
            default: next = ST_HIZ;
        endcase
        if (stby) begin
            next = ST_STANDBY;
        end else if (tsd || !en) begin
            next = ST_HIZ;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HIZ;
            dir_q <= 1'b1;
        end else begin
            state <= next;
            if ((next == ST_DRIVE) && (state != ST_DRIVE)) begin
                dir_q <= dir;
            end
        end
    end

    // control outputs to the timers
    always_comb begin
        dead_load = is_dead(next) && (next != state);
        off_arm   = ((state == ST_DRIVE) && (next == ST_DEAD_BRK)) ||
                    ((state == ST_BRAKE) && (next == ST_BRAKE) && off_done && trip);
        off_clear = (next == ST_STANDBY) || (next == ST_HIZ);
    end

    // R6: drive never steps straight into brake
    a_r6_no_direct_brake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE) |=> (state != ST_BRAKE));

    // R8: brake never steps straight into drive
    a_r8_no_direct_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRAKE) |=> (state != ST_DRIVE));

    // R10: until the timer expires, brake ignores the trip flag
    a_r10_brake_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BRAKE) && !off_done && en && !stby && !tsd) |=> (state == ST_BRAKE));

    // R3: standby always lands in the standby state
    a_r3_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
        stby |=> (state == ST_STANDBY));

endmodule

// File: rtl/chop_gate_decode.sv
module chop_gate_decode
    import chop_pkg::*;
(
    input  chop_state_e state,
    input  logic        dir_q,
    output gate_cmd_t   gates
);
    always_comb begin
        gates = '0;
        unique case (state)
            ST_DRIVE: begin
                if (dir_q) begin
                    gates.hi1 = 1'b1;
                    gates.lo2 = 1'b1;
                end else begin
                    gates.hi2 = 1'b1;
                    gates.lo1 = 1'b1;
                end
            end
            ST_BRAKE: begin
                gates.lo1 = 1'b1;
                gates.lo2 = 1'b1;
            end
            ST_STANDBY, ST_HIZ, ST_DEAD_BRK, ST_DEAD_DRV, ST_DEAD_DIR: begin
                gates = '0;
            end
            default: gates = '0;
        endcase
    end
endmodule

// File: rtl/hbridge_chopper_ctrl.sv
module hbridge_chopper_ctrl
    import chop_pkg::*;
#(
    parameter int DEAD_CYCLES = 40,
    parameter int OFF_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dir,
    input  logic trip,
    input  logic osc,
    input  logic stby,
    input  logic tsd,
    output logic leg1_hi,
    output logic leg1_lo,
    output logic leg2_hi,
    output logic leg2_lo
);
    chop_state_e state;
    logic        dir_q;
    logic        dead_load;
    logic        dead_done;
    logic        off_arm;
    logic        off_clear;
    logic        off_done;
    gate_cmd_t   gates;

    chop_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dir       (dir),
        .trip      (trip),
        .stby      (stby),
        .tsd       (tsd),
        .dead_done (dead_done),
        .off_done  (off_done),
        .state     (state),
        .dir_q     (dir_q),
        .dead_load (dead_load),
        .off_arm   (off_arm),
        .off_clear (off_clear)
    );

    chop_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dead_load),
        .done  (dead_done)
    );

    chop_off_timer #(.OFF_PERIODS(OFF_PERIODS)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .osc   (osc),
        .arm   (off_arm),
        .clear (off_clear),
        .done  (off_done)
    );

    chop_gate_decode u_dec (
        .state (state),
        .dir_q (dir_q),
        .gates (gates)
    );

    assign leg1_hi = gates.hi1;
    assign leg1_lo = gates.lo1;
    assign leg2_hi = gates.hi2;
    assign leg2_lo = gates.lo2;

    // R12: no leg ever has both of its switches on
    a_r12_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg1_hi && leg1_lo) && !(leg2_hi && leg2_lo));

    // R1: disabled channel floats on the following cycle
    a_r1_disable_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(leg1_hi || leg1_lo || leg2_hi || leg2_lo));

    // R4: thermal fault forces all gates off
    a_r4_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        tsd |=> !(leg1_hi || leg1_lo || leg2_hi || leg2_lo));

    // R5: a trip while a high side conducts removes the high side
    a_r5_trip_cuts_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((leg1_hi || leg2_hi) && trip) |=> !(leg1_hi || leg2_hi));

endmodule

// File: tb/test_hbridge_chopper_ctrl.sv
`timescale 1ns/100ps
module test_hbridge_chopper_ctrl;

    localparam int DT = 8;
    localparam logic [3:0] G_OFF = 4'b0000;
    localparam logic [3:0] G_FWD = 4'b1001;
    localparam logic [3:0] G_REV = 4'b0110;
    localparam logic [3:0] G_BRK = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b1, trip = 1'b0, osc = 1'b0, stby = 1'b0, tsd = 1'b0;
    logic leg1_hi, leg1_lo, leg2_hi, leg2_lo;

    int n_checks = 0;
    int n_fail = 0;
    int n_overlap = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hbridge_chopper_ctrl #(.DEAD_CYCLES(DT), .OFF_PERIODS(2)) i_hbridge_chopper_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .trip(trip), .osc(osc),
        .stby(stby), .tsd(tsd),
        .leg1_hi(leg1_hi), .leg1_lo(leg1_lo), .leg2_hi(leg2_hi), .leg2_lo(leg2_lo)
    );

    wire [3:0] gates = {leg1_hi, leg1_lo, leg2_hi, leg2_lo};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        n_checks++;
        if (gates !== exp) begin
            n_fail++;
            $display("FAIL %s: gates actual %b expected %b", tag, gates, exp);
        end
    endtask

    task automatic osc_edge();
        osc = 1'b1;
        tick();
        osc = 1'b0;
        tick();
    endtask

    // already in the first dead cycle; DT-1 more off cycles then exp
    task automatic finish_dead(input logic [3:0] exp, input string tag);
        for (int i = 1; i < DT; i++) tick();
        chk(G_OFF, {tag, " last dead cycle"});
        tick();
        chk(exp, {tag, " after dead time"});
    endtask

    task automatic go_brake();
        trip = 1'b1;
        tick();
        chk(G_OFF, "R5 trip cuts drive");
        trip = 1'b0;
        finish_dead(G_BRK, "R6");
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk(G_OFF, "reset state");
        rst_n = 1'b1;
        tick();
        chk(G_OFF, "R1 idle after reset with en low");
    endtask

    task automatic t_enable();
        dir = 1'b0;
        tick();
        chk(G_OFF, "R1 dir toggled while disabled");
        dir = 1'b1; en = 1'b1;
        tick();
        chk(G_FWD, "R2 forward");
        en = 1'b0;
        tick();
        chk(G_OFF, "R1 disable");
        dir = 1'b0; en = 1'b1;
        tick();
        chk(G_REV, "R2 reverse");
        en = 1'b0;
        tick();
        dir = 1'b1; en = 1'b1;
        tick();
        chk(G_FWD, "R2 forward again");
    endtask

    task automatic t_chop();
        go_brake();
        osc_edge();
        chk(G_BRK, "R7 brake after start edge");
        trip = 1'b1;
        tick();
        trip = 1'b0;
        chk(G_BRK, "R10 trip pulse in brake ignored");
        osc_edge();
        chk(G_BRK, "R7 brake after second edge");
        osc_edge();
        chk(G_OFF, "R8 dead after expiry");
        trip = 1'b1;
        tick();
        trip = 1'b0;
        chk(G_OFF, "R10 trip in dead ignored");
        for (int i = 2; i < DT; i++) tick();
        chk(G_OFF, "R8 last dead cycle");
        tick();
        chk(G_FWD, "R8 drive resumes");
    endtask

    task automatic t_retrigger();
        go_brake();
        osc_edge();
        osc_edge();
        chk(G_BRK, "R11 brake before expiry");
        trip = 1'b1;
        osc_edge();
        chk(G_BRK, "R11 trip at expiry keeps brake");
        trip = 1'b0;
        tick();
        chk(G_BRK, "R11 brake continues");
        osc_edge();
        osc_edge();
        chk(G_BRK, "R11 new period not yet over");
        osc_edge();
        chk(G_OFF, "R11 new period expiry");
        finish_dead(G_FWD, "R8");
    endtask

    task automatic t_dir();
        dir = 1'b0;
        tick();
        chk(G_OFF, "R9 reversal dead start");
        finish_dead(G_REV, "R9");
        dir = 1'b1;
        tick();
        chk(G_OFF, "R9 reversal back dead start");
        finish_dead(G_FWD, "R9");
    endtask

    task automatic t_standby();
        go_brake();
        osc_edge();
        stby = 1'b1;
        tick();
        chk(G_OFF, "R3 standby during brake");
        tick();
        chk(G_OFF, "R3 standby held");
        stby = 1'b0;
        tick();
        chk(G_FWD, "R3 drive after standby, timer cleared");
    endtask

    task automatic t_thermal();
        tsd = 1'b1;
        tick();
        chk(G_OFF, "R4 fault off");
        dir = 1'b0;
        tick();
        chk(G_OFF, "R4 fault overrides dir");
        dir = 1'b1;
        tsd = 1'b0;
        tick();
        chk(G_FWD, "R4 drive after fault");
    endtask

    // R12 monitor
    always @(negedge clk) begin
        if (rst_n && ((leg1_hi && leg1_lo) || (leg2_hi && leg2_lo))) begin
            n_overlap++;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_enable();
        t_chop();
        t_retrigger();
        t_dir();
        t_standby();
        t_thermal();
        n_checks++;
        if (n_overlap != 0) begin
            n_fail++;
            $display("FAIL R12 leg overlap cycles actual %0d expected 0", n_overlap);
        end
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        summary();
    end

endmodule